// File: doc/BRIEF.md
# Sequential-Access Address Generator

This block is the address stage of a small 32-bit processor. A dedicated address register holds the byte address of the memory access in progress. When the bus controller signals that the access has completed, the register moves on to its next value. That value is either the current address plus one word, taken from an incrementer tied to the address register, or a new address loaded for a branch, an exception vector or a random data access. Because the next address is computed from the address register itself, it is ready at the clock edge that ends the current access.

Alongside the address the block drives a registered sequential hint. The hint tells the memory controller that the current address is exactly one word beyond the previous one, so an open DRAM page can be reused. Any explicit load clears the hint and forces a full, non-sequential cycle.

The incremented address also feeds a write-back port that updates the program counter, so the program counter has no incrementer of its own. A burst flag marks load/store-multiple transfers. These transfers step through data words on the same incrementer and are flagged sequential after their first word, but they leave the program counter alone.

Top module: `seq_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `addr_o` equals RESET_ADDR (default 0), `seq_o` is 0, `pc_we_o` is 0 and `pc_wb_o` is 0. The first access after reset is therefore non-sequential.
- R2: At an edge where `adv_i`=1 and `load_i`=0, `addr_o` becomes the old address plus WORD_BYTES (4) after that edge.
- R3: After an edge with `adv_i`=1 and `load_i`=0, `seq_o` is 1.
- R4: At an edge where `adv_i`=1 and `load_i`=1, `addr_o` becomes `load_addr_i` with its low log2(WORD_BYTES) bits (bits 1:0) forced to 0, and `seq_o` becomes 0.
- R5: At an edge where `adv_i`=0, `addr_o` and `seq_o` keep their values and `pc_we_o` becomes 0. `load_i`, `load_addr_i` and `burst_i` have no effect at such an edge.
- R6: At an edge with `adv_i`=1, `load_i`=0 and `burst_i`=0, `pc_we_o` becomes 1 for one cycle and `pc_wb_o` becomes the new `addr_o`. At any other edge `pc_we_o` becomes 0 and `pc_wb_o` keeps its value.
- R7: A burst begun by a load with `burst_i`=1 is non-sequential on its first word. Each following advance with `burst_i`=1 steps by one word with `seq_o`=1, and none of these edges writes the program counter.
- R8: Incrementing from the top word (0xFFFFFFFC) wraps to 0 modulo 2^ADDR_W, and `seq_o` is 1 after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Access completes this cycle; gates every state change |
| load_i | input | 1 | Take `load_addr_i` instead of incrementing |
| load_addr_i | input | ADDR_W | New address for a branch, vector or data access |
| burst_i | input | 1 | Multi-word transfer: increment without program-counter write-back |
| addr_o | output | ADDR_W | Current access address (registered) |
| seq_o | output | 1 | Current address is one word after the previous one |
| pc_wb_o | output | ADDR_W | Incremented address for the program counter |
| pc_we_o | output | 1 | Write strobe for `pc_wb_o`, one cycle |

## Verification
Every result of this block is registered once, so every output reflects the inputs sampled at the previous rising edge. The address, the hint and the write-back strobe are all due exactly one cycle after the stimulus. The bench drives inputs on the falling edge and steps a behavioural model at each rising edge. One time unit after that edge it compares all four outputs with the model, which places every comparison in the cycle its result is due. Stall runs, misaligned loads, bursts and the wrap at the top of the address space are forced explicitly, and a long random mix follows them.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // Source selected for the next address register value
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INC  = 2'd1,
    SRC_LOAD = 2'd2
  } nxt_src_e;
endpackage

// File: rtl/sag_step_inc.sv
module sag_step_inc #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] cur_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam int LSB = $clog2(WORD_BYTES);
  localparam int HI_W = ADDR_W - LSB;

  generate
    if (LSB == 0) begin : g_byte
      assign nxt_o = cur_i + ADDR_W'(1);
    end else begin : g_word
      // Only the word index is incremented; byte lanes pass through.
      logic [HI_W-1:0] word_idx;
      assign word_idx = cur_i[ADDR_W-1:LSB] + HI_W'(1);
      assign nxt_o    = {word_idx, cur_i[LSB-1:0]};
    end
  endgenerate
endmodule

// File: rtl/sag_src_sel.sv
module sag_src_sel
  import sag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              adv_i,
  input  logic              load_i,
  input  logic              burst_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic              cur_seq_i,
  input  logic [ADDR_W-1:0] inc_addr_i,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic              nxt_seq_o,
  output logic              wb_en_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

  nxt_src_e src;

  always_comb begin
    if (!adv_i)      src = SRC_HOLD;
    else if (load_i) src = SRC_LOAD;
    else             src = SRC_INC;
  end

  always_comb begin
    nxt_addr_o = cur_addr_i;
    nxt_seq_o  = cur_seq_i;
    wb_en_o    = 1'b0;
    case (src)
      SRC_INC: begin
        nxt_addr_o = inc_addr_i;
        nxt_seq_o  = 1'b1;
        wb_en_o    = !burst_i;
      end
      SRC_LOAD: begin
        nxt_addr_o = load_addr_i & ALIGN_MASK;
        nxt_seq_o  = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sag_pc_wb.sv
module sag_pc_wb #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_en_i,
  input  logic [ADDR_W-1:0] wb_val_i,
  output logic [ADDR_W-1:0] pc_wb_o,
  output logic              pc_we_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_wb_o <= '0;
      pc_we_o <= 1'b0;
    end else begin
      pc_we_o <= wb_en_i;
      if (wb_en_i) pc_wb_o <= wb_val_i;
    end
  end
endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen #(
  parameter int                ADDR_W     = 32,
  parameter int                WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              burst_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              seq_o,
  output logic [ADDR_W-1:0] pc_wb_o,
  output logic              pc_we_o
);
  logic [ADDR_W-1:0] addr_q, inc_addr, nxt_addr;
  logic              seq_q, nxt_seq, wb_en;

  sag_step_inc #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_inc (
    .cur_i (addr_q),
    .nxt_o (inc_addr)
  );

  sag_src_sel #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_sel (
    .adv_i       (adv_i),
    .load_i      (load_i),
    .burst_i     (burst_i),
    .load_addr_i (load_addr_i),
    .cur_addr_i  (addr_q),
    .cur_seq_i   (seq_q),
    .inc_addr_i  (inc_addr),
    .nxt_addr_o  (nxt_addr),
    .nxt_seq_o   (nxt_seq),
    .wb_en_o     (wb_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= RESET_ADDR;
      seq_q  <= 1'b0;
    end else begin
      addr_q <= nxt_addr;
      seq_q  <= nxt_seq;
    end
  end

  sag_pc_wb #(.ADDR_W(ADDR_W)) u_wb (
    .clk      (clk),
    .rst      (rst),
    .wb_en_i  (wb_en),
    .wb_val_i (inc_addr),
    .pc_wb_o  (pc_wb_o),
    .pc_we_o  (pc_we_o)
  );

  assign addr_o = addr_q;
  assign seq_o  = seq_q;
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_i,
  input logic              load_i,
  input logic [ADDR_W-1:0] load_addr_i,
  input logic              burst_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              seq_o,
  input logic [ADDR_W-1:0] pc_wb_o,
  input logic              pc_we_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (addr_o == RESET_ADDR && !seq_o && !pc_we_o));

  // R2
  step_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i) |=> addr_o == $past(addr_o) + STEP);

  // R3
  seq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i) |=> seq_o);

  // R4
  load_nonseq_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && load_i) |=> (!seq_o && addr_o == ($past(load_addr_i) & ALIGN_MASK)));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> ($stable(addr_o) && $stable(seq_o) && !pc_we_o));

  // R6
  wb_match_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we_o |-> pc_wb_o == addr_o);

  // R7
  burst_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && burst_i) |=> !pc_we_o);
endmodule

bind seq_addr_gen sag_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .RESET_ADDR(RESET_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .adv_i(adv_i), .load_i(load_i),
  .load_addr_i(load_addr_i), .burst_i(burst_i), .addr_o(addr_o),
  .seq_o(seq_o), .pc_wb_o(pc_wb_o), .pc_we_o(pc_we_o)
);

// File: tb/tb_seq_addr_gen.sv
`timescale 1ns/1ps
module tb_seq_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_i = 1'b0, load_i = 1'b0, burst_i = 1'b0;
  logic [31:0] load_addr_i = '0;
  logic [31:0] addr_o, pc_wb_o;
  logic        seq_o, pc_we_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_addr, m_wb;
  logic        m_seq, m_we;

  always #2.5 clk = ~clk;

  seq_addr_gen dut (
    .clk(clk), .rst(rst), .adv_i(adv_i), .load_i(load_i),
    .load_addr_i(load_addr_i), .burst_i(burst_i), .addr_o(addr_o),
    .seq_o(seq_o), .pc_wb_o(pc_wb_o), .pc_we_o(pc_we_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: drive at falling edge, update model at rising edge, compare after it.
  task automatic step(bit r, bit a, bit l, logic [31:0] la, bit b);
    string tag, stag, wtag;
    bit wrap;
    @(negedge clk);
    rst = r; adv_i = a; load_i = l; load_addr_i = la; burst_i = b;
    wrap = (m_addr == 32'hFFFF_FFFC);
    if (r)           tag = "R1";
    else if (!a)     tag = "R5";
    else if (l)      tag = "R4";
    else if (wrap)   tag = "R8";
    else if (b)      tag = "R7";
    else             tag = "R2";
    stag = (tag == "R2") ? "R3" : tag;
    wtag = (!r && a && !l && !b) ? "R6" : tag;
    @(posedge clk);
    if (r) begin
      m_addr = 32'h0; m_seq = 0; m_we = 0; m_wb = 32'h0;
    end else if (a && l) begin
      m_addr = la & 32'hFFFF_FFFC; m_seq = 0; m_we = 0;
    end else if (a) begin
      m_addr = m_addr + 32'd4; m_seq = 1; m_we = !b;
      if (!b) m_wb = m_addr;
    end else begin
      m_we = 0;
    end
    #1;
    chk(tag,  "addr",  addr_o,          m_addr);
    chk(stag, "seq",   {31'b0, seq_o},  {31'b0, m_seq});
    chk(wtag, "pc_we", {31'b0, pc_we_o},{31'b0, m_we});
    chk(wtag, "pc_wb", pc_wb_o,         m_wb);
  endtask

  initial begin
    m_addr = 0; m_seq = 0; m_we = 0; m_wb = 0;
    // R1: reset state and first access non-sequential
    step(1, 0, 0, 0, 0);
    step(1, 1, 1, 32'h55, 1);
    // R2 R3 R6: straight-line fetches
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0);
    // R5: stall with load and burst toggled must not disturb anything
    step(0, 0, 1, 32'hDEAD_BEE0, 0);
    step(0, 0, 1, 32'h1234_5678, 1);
    step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    // R4: misaligned branch target, cleared low bits, non-sequential
    step(0, 1, 1, 32'h0000_1003, 0);
    step(0, 1, 0, 0, 0);
    // R7: burst of four words after a data-address load
    step(0, 1, 1, 32'h0000_8000, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0);
    // R8: wrap at the top of the address space
    step(0, 1, 1, 32'hFFFF_FFF8, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0);
    // mid-run reset, R1 again
    step(1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[9:0] == 0, rv[1] | rv[2], rv[3] & rv[4], $urandom, rv[5]);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule